// File: doc/BRIEF.md
# Early-Exit Sequential Multiplier

This block multiplies two 32-bit operands and returns the low 32 bits of their product. It works one radix-4 digit of the second operand per clock: each step adds zero, one, two or three times the shifted first operand into an accumulator, then shifts that operand left by two and the second operand right by two. As soon as the unconsumed part of the second operand is zero the loop ends, so small multipliers finish early.

A client pulses `go_i` with both operands while the unit is idle. `busy_o` is high until the answer appears. `done_o` then pulses for one cycle, and `prod_o` holds the result until the next operation completes. The total latency, counted in clock edges from the edge that accepts `go_i` to the edge that raises `done_o`, is three fixed cycles plus one cycle for every two bits of the second operand's significant length.

Top module: `mul_early_exit`

## Requirements
- R1: `prod_o` equals the low 32 bits of `opa_i * opb_i` as sampled on the accepting edge, for any operand values, with overflow beyond bit 31 dropped.
- R2: If the second operand has n significant bits (n = 0 when it is zero), `done_o` rises exactly 3 + ceil(n/2) clock edges after the edge that accepts `go_i`. A zero second operand takes 3 edges, and any nonzero value takes at least 4.
- R3: `busy_o` is high from the accepting edge until the edge that raises `done_o`, and it is low whenever `done_o` is high.
- R4: `done_o` is high for exactly one cycle per accepted operation.
- R5: `prod_o` changes only on the edge that raises `done_o`. Operand changes without an accepted start leave it unchanged.
- R6: `go_i` asserted while `busy_o` is high is ignored: it changes neither the result nor the latency of the operation in flight.
- R7: `go_i` is accepted in the same cycle that `done_o` is high, so operations can run back to back.
- R8: After reset, `busy_o` and `done_o` are low and `prod_o` is zero.

Only the latency of R2 depends on the second operand. The value of the first operand has no effect on timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| go_i | input | 1 | Start request, taken while idle |
| opa_i | input | 32 | Multiplicand |
| opb_i | input | 32 | Multiplier; its length sets the latency |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| prod_o | output | 32 | Low 32 bits of the product |

## Verification
The completion pulse of one operation and the acceptance of the next start can fall in the same cycle. The bench drives `go_i` with fresh operands in the very cycle it sees `done_o` high. It then checks that the next cycle shows `busy_o` high and `done_o` low, that the first result was delivered intact, and that the second operation's product and edge count match the reference computed from its operands. A separate scenario raises `go_i` with different operands in mid-flight and expects no change to either value or timing.

// File: rtl/mul_pkg.sv
package mul_pkg;
  localparam int unsigned MUL_W    = 32;
  localparam int unsigned MUL_STEP = 2;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_ITER  = 3'd2,
    ST_WRAP  = 3'd3,
    ST_FIN   = 3'd4
  } mul_state_t;
endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_pkg::*;
#(
  parameter int unsigned W    = MUL_W,
  parameter int unsigned STEP = MUL_STEP
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  input  logic b_zero_i,
  input  logic b_rest_zero_i,
  output logic load_o,
  output logic step_o,
  output logic commit_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned MAX_ITER = (W + STEP - 1) / STEP;
  localparam int unsigned CNT_W    = $clog2(MAX_ITER + 2);

  mul_state_t state_q, state_d;
  logic       done_q, done_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (go_i) state_d = ST_SETUP;
      ST_SETUP: state_d = b_zero_i ? ST_WRAP : ST_ITER;
      ST_ITER:  if (b_rest_zero_i) state_d = ST_WRAP;
      ST_WRAP:  state_d = ST_FIN;
      ST_FIN:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign done_d   = (state_q == ST_FIN);
  assign load_o   = (state_q == ST_IDLE) && go_i;
  assign step_o   = (state_q == ST_ITER);
  assign commit_o = (state_q == ST_FIN);
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  // Checker counter: steps taken in the current operation
  logic [CNT_W-1:0] chk_iter_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       chk_iter_q <= '0;
    else if (load_o)  chk_iter_q <= '0;
    else if (step_o)  chk_iter_q <= chk_iter_q + 1'b1;
  end

  p_iter_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |-> (chk_iter_q < CNT_W'(MAX_ITER)));

  p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && go_i) |=> (state_q != ST_SETUP));

  p_done_not_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath
  import mul_pkg::*;
#(
  parameter int unsigned W    = MUL_W,
  parameter int unsigned STEP = MUL_STEP
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic         commit_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic         b_zero_o,
  output logic         b_rest_zero_o,
  output logic [W-1:0] prod_o
);
  logic [W-1:0] a_q, a_d;
  logic [W-1:0] b_q, b_d;
  logic [W-1:0] acc_q, acc_d;
  logic [W-1:0] res_q, res_d;
  logic [W-1:0] term [STEP];
  logic [W-1:0] digit_sum;

  // One partial product per bit of the current digit
  for (genvar j = 0; j < STEP; j++) begin : g_term
    assign term[j] = b_q[j] ? (a_q << j) : '0;
  end

  always_comb begin
    digit_sum = '0;
    for (int j = 0; j < STEP; j++) digit_sum = digit_sum + term[j];
  end

  assign b_zero_o      = (b_q == '0);
  assign b_rest_zero_o = ((b_q >> STEP) == '0);

  always_comb begin
    a_d   = a_q;
    b_d   = b_q;
    acc_d = acc_q;
    res_d = res_q;
    if (load_i) begin
      a_d   = opa_i;
      b_d   = opb_i;
      acc_d = '0;
    end else if (step_i) begin
      acc_d = acc_q + digit_sum;
      a_d   = a_q << STEP;
      b_d   = b_q >> STEP;
    end
    if (commit_i) res_d = acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      acc_q <= '0;
      res_q <= '0;
    end else begin
      a_q   <= a_d;
      b_q   <= b_d;
      acc_q <= acc_d;
      res_q <= res_d;
    end
  end

  assign prod_o = res_q;

  p_no_empty_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> !b_zero_o);

  p_result_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(commit_i) |-> $stable(res_q));
endmodule

// File: rtl/mul_early_exit.sv
module mul_early_exit
  import mul_pkg::*;
#(
  parameter int unsigned W    = MUL_W,
  parameter int unsigned STEP = MUL_STEP
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] prod_o
);
  logic load, step, commit, b_zero, b_rest_zero;

  mul_ctrl #(.W(W), .STEP(STEP)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .go_i          (go_i),
    .b_zero_i      (b_zero),
    .b_rest_zero_i (b_rest_zero),
    .load_o        (load),
    .step_o        (step),
    .commit_o      (commit),
    .busy_o        (busy_o),
    .done_o        (done_o)
  );

  mul_datapath #(.W(W), .STEP(STEP)) u_dp (
    .clk           (clk),
    .rst_n         (rst_n),
    .load_i        (load),
    .step_i        (step),
    .commit_i      (commit),
    .opa_i         (opa_i),
    .opb_i         (opb_i),
    .b_zero_o      (b_zero),
    .b_rest_zero_o (b_rest_zero),
    .prod_o        (prod_o)
  );

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_prod_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(prod_o));
endmodule

// File: tb/sim_mul_early_exit.sv
module sim_mul_early_exit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        go_i;
  logic [31:0] opa_i, opb_i;
  logic        busy_o, done_o;
  logic [31:0] prod_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  mul_early_exit u0 (
    .clk(clk), .rst_n(rst_n), .go_i(go_i), .opa_i(opa_i), .opb_i(opb_i),
    .busy_o(busy_o), .done_o(done_o), .prod_o(prod_o)
  );

  function automatic int ref_lat(input logic [31:0] b);
    int bl = 0;
    for (int i = 0; i < 32; i++) if (b[i]) bl = i + 1;
    return 3 + (bl + 1) / 2;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive go_i in the current low phase; returns just after the accepting edge
  task automatic start_op(input logic [31:0] a, input logic [31:0] b);
    go_i = 1'b1; opa_i = a; opb_i = b;
    @(negedge clk);
    go_i = 1'b0;
  endtask

  // Counts edges after acceptance until done; optional mid-flight start (R6)
  task automatic wait_done(input logic [31:0] a, input logic [31:0] b, input bit inject);
    int n = 0;
    check("R3 busy after accept", {31'd0, busy_o}, 32'd1);
    while (!done_o && n < 100) begin
      if (inject && n == 1) begin go_i = 1'b1; opa_i = ~a; opb_i = 32'hFFFF_FFFF; end
      if (inject && n == 2) go_i = 1'b0;
      @(negedge clk);
      n++;
      if (!done_o) check("R3 busy until done", {31'd0, busy_o}, 32'd1);
    end
    go_i = 1'b0;
    check("R2 latency", n, ref_lat(b));
    check("R1 product", prod_o, a * b);
    check("R3 not busy with done", {31'd0, busy_o}, 32'd0);
  endtask

  task automatic t_single(input logic [31:0] a, input logic [31:0] b);
    start_op(a, b);
    wait_done(a, b, 1'b0);
    @(negedge clk);
    check("R4 done single pulse", {31'd0, done_o}, 32'd0);
  endtask

  task automatic t_hold();
    logic [31:0] keep;
    t_single(32'h1234_5678, 32'h0000_0345);
    keep = prod_o;
    opa_i = 32'hDEAD_BEEF; opb_i = 32'h7;
    repeat (6) @(negedge clk);
    check("R5 result held", prod_o, keep);
    check("R5 no spurious done", {31'd0, done_o}, 32'd0);
  endtask

  task automatic t_ignore();
    start_op(32'h0000_0ABC, 32'h0000_1001);
    wait_done(32'h0000_0ABC, 32'h0000_1001, 1'b1);
    @(negedge clk);
    check("R6 no second op", {31'd0, busy_o}, 32'd0);
  endtask

  task automatic t_chain();
    start_op(32'h0000_0013, 32'h0000_00FF);
    wait_done(32'h0000_0013, 32'h0000_00FF, 1'b0);
    start_op(32'hFFFF_FFFF, 32'h0000_0000);      // R7: go_i during done cycle
    check("R7 accepted with done", {31'd0, done_o}, 32'd0);
    wait_done(32'hFFFF_FFFF, 32'h0000_0000, 1'b0);
    start_op(32'h8000_0001, 32'h0000_0003);
    wait_done(32'h8000_0001, 32'h0000_0003, 1'b0);
    @(negedge clk);
  endtask

  initial begin
    #500us;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; go_i = 1'b0; opa_i = '0; opb_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 reset busy", {31'd0, busy_o}, 32'd0);
    check("R8 reset done", {31'd0, done_o}, 32'd0);
    check("R8 reset prod", prod_o, 32'd0);

    t_single(32'h0000_0007, 32'h0000_0000);   // R2 minimum
    t_single(32'h0000_0007, 32'h0000_0001);   // R2 one step
    t_single(32'h0000_0009, 32'h0000_0002);
    t_single(32'h0000_0009, 32'h0000_0003);
    t_single(32'h0000_0009, 32'h0000_0004);
    t_single(32'h0000_0000, 32'hFFFF_FFFF);   // R2 A irrelevant
    t_single(32'hFFFF_FFFF, 32'hFFFF_FFFF);   // R1 overflow
    t_single(32'h8000_0000, 32'h8000_0000);
    t_single(32'h0001_0000, 32'h0001_0000);
    for (int i = 0; i < 40; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      rb = $urandom >> (i % 32);
      t_single(ra, rb);
    end
    t_hold();
    t_ignore();
    t_chain();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule